// File: doc/BRIEF.md
# Bus Target Control Register with Self-Clearing Bits

This block is the control register of a bus target that runs SDR and HDR transfers. Software reaches it through a plain write/read port. It holds four fields:

- a bus-error detection enable;
- a request to leave HDR mode early;
- a selector that lets the target run SDR transfers on its static address;
- a one-shot that arms the answer to the next private or legacy-I2C transfer request.

Two of the fields are set by software and cleared by hardware events. When a software write and a hardware clear hit the same bit in the same cycle, the write wins.

From the register and a few status inputs, the block drives three decisions for the protocol engine around it:

- a level request to leave HDR mode;
- a flag that the target is running SDR on its static address;
- an ACK/NACK choice, qualified by address match.

Top module: `tgt_ctl_reg`

## Requirements
- R1: After reset, `cpu_rdata` is 0x00 and `force_exit_req` and `static_sdr_active` are 0. Register layout: bit 3 error-detect enable, bit 2 force-exit, bit 1 static-SDR select, bit 0 ACK one-shot.
- R2: Bits 7 to 4 of `cpu_rdata` always read 0, and writing 1s to them changes nothing. Bits 3 and 1 take the written value.
- R3: `op_mode` encodes SDR as 2'b0x and HDR as 2'b1x. A write of 1 to bit 2 is discarded while `op_mode[1]` is 0, and is taken while it is 1. `force_exit_req` equals bit 2 and stays high until that bit is cleared.
- R4: Bit 2 clears on the clock edge after `hdr_exit_done` is seen with no write in that cycle. A software write of 0 to bit 2 also clears it.
- R5: `static_sdr_active` is 1 exactly when bit 1 is set and `dyn_addr_valid` is 0.
- R6: With `ackp_en` at 1, `ack_decision` (1 = ACK, 0 = NACK) equals bit 0. `ack_decision_valid` equals `addr_match`.
- R7: With `ackp_en` at 0, `ack_decision` is 1 whatever bit 0 holds.
- R8: Bit 0 clears on the clock edge after `ack_sent` is seen with no write in that cycle.
- R9: When a write lands in the same cycle as `hdr_exit_done` or `ack_sent`, the written values of bits 2 and 0 are kept.
- R10: A write shows on `cpu_rdata` after the clock edge that samples `cpu_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr_en | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Register read value |
| op_mode | input | 2 | Operating mode, bit 1 set means HDR |
| hdr_exit_done | input | 1 | HDR-to-SDR transition completed |
| addr_match | input | 1 | Private/I2C request matched this target |
| ack_sent | input | 1 | ACK was driven for a private/I2C request |
| dyn_addr_valid | input | 1 | A dynamic address has been assigned |
| ackp_en | input | 1 | ACK-policy enable for the one-shot |
| force_exit_req | output | 1 | Level request to leave HDR mode |
| static_sdr_active | output | 1 | Target runs SDR on its static address |
| ack_decision | output | 1 | 1 = ACK, 0 = NACK for the matched request |
| ack_decision_valid | output | 1 | `ack_decision` is meaningful this cycle |

## Verification
The bench goes after the cycles where software and hardware touch the same bit together. A design that let the hardware clear win would drop the one-shot or the exit request that software had just armed.

It writes the force-exit bit in both SDR encodings. A design that decoded only one bit of `op_mode` would latch a request that must be ignored.

It toggles `ackp_en` while the one-shot is clear. A design that always used the one-shot would NACK a request that must be ACKed.

Writes of 1s to the upper nibble expose a register that stores or returns them.

// File: rtl/tgt_ctl_pkg.sv
package tgt_ctl_pkg;
  localparam int REG_W     = 8;
  localparam int FLD_W     = 4;
  localparam int MODE_W    = 2;
  localparam int B_ERRDET  = 3;
  localparam int B_FEXIT   = 2;
  localparam int B_STATSDR = 1;
  localparam int B_ACKONE  = 0;

  // HDR is signalled by the upper mode bit; 2'b0x is SDR.
  function automatic logic mode_is_hdr(input logic [MODE_W-1:0] mode);
    return mode[MODE_W-1];
  endfunction

  // A software 1 to the exit bit only counts in HDR mode.
  function automatic logic fexit_write_val(input logic d,
                                           input logic [MODE_W-1:0] mode);
    return d & mode_is_hdr(mode);
  endfunction

  // With the policy off, matched requests are always acknowledged.
  function automatic logic ack_choice(input logic policy_on, input logic one_shot);
    return policy_on ? one_shot : 1'b1;
  endfunction
endpackage

// File: rtl/tgt_ctl_bit.sv
module tgt_ctl_bit #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_we,
  input  logic sw_d,
  input  logic hw_clr,
  output logic q
);
  // Software write has priority over the hardware clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RST_VAL;
    else if (sw_we)  q <= sw_d;
    else if (hw_clr) q <= 1'b0;
  end
endmodule

// File: rtl/tgt_ctl_ack_dec.sv
module tgt_ctl_ack_dec (
  input  logic policy_on,
  input  logic one_shot,
  input  logic match,
  output logic decision,
  output logic decision_valid
);
  import tgt_ctl_pkg::*;
  assign decision       = ack_choice(policy_on, one_shot);
  assign decision_valid = match;
endmodule

// File: rtl/tgt_ctl_reg.sv
module tgt_ctl_reg
  import tgt_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              hdr_exit_done,
  input  logic              addr_match,
  input  logic              ack_sent,
  input  logic              dyn_addr_valid,
  input  logic              ackp_en,
  output logic              force_exit_req,
  output logic              static_sdr_active,
  output logic              ack_decision,
  output logic              ack_decision_valid
);
  // Per-bit write data and hardware clear events.
  logic [FLD_W-1:0] fld_q;
  logic [FLD_W-1:0] wr_d;
  logic [FLD_W-1:0] hw_clr;

  // Named events, brought out for the checker.
  logic fexit_hw_clr;
  logic ackone_hw_clr;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^cpu_wdata[REG_W-1:FLD_W];
  assign fexit_hw_clr    = hdr_exit_done;
  assign ackone_hw_clr   = ack_sent;

  always_comb begin
    wr_d              = cpu_wdata[FLD_W-1:0];
    wr_d[B_FEXIT]     = fexit_write_val(cpu_wdata[B_FEXIT], op_mode);
    hw_clr            = '0;
    hw_clr[B_FEXIT]   = fexit_hw_clr;
    hw_clr[B_ACKONE]  = ackone_hw_clr;
  end

  for (genvar i = 0; i < FLD_W; i++) begin : g_fld
    tgt_ctl_bit #(.RST_VAL(1'b0)) u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_we  (cpu_wr_en),
      .sw_d   (wr_d[i]),
      .hw_clr (hw_clr[i]),
      .q      (fld_q[i])
    );
  end

  assign cpu_rdata         = {{(REG_W-FLD_W){1'b0}}, fld_q};
  assign force_exit_req    = fld_q[B_FEXIT];
  assign static_sdr_active = fld_q[B_STATSDR] & ~dyn_addr_valid;

  tgt_ctl_ack_dec u_ack (
    .policy_on      (ackp_en),
    .one_shot       (fld_q[B_ACKONE]),
    .match          (addr_match),
    .decision       (ack_decision),
    .decision_valid (ack_decision_valid)
  );
endmodule

// File: rtl/tgt_ctl_reg_chk.sv
module tgt_ctl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_wr_en,
  input logic [7:0] cpu_wdata,
  input logic [7:0] cpu_rdata,
  input logic [1:0] op_mode,
  input logic       fexit_hw_clr,
  input logic       ackone_hw_clr,
  input logic       addr_match,
  input logic       dyn_addr_valid,
  input logic       ackp_en,
  input logic       force_exit_req,
  input logic       static_sdr_active,
  input logic       ack_decision,
  input logic       ack_decision_valid
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (cpu_rdata == 8'h00));

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[7:4] == 4'h0);

  assert_fexit_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && !op_mode[1]) |=> !force_exit_req);

  assert_fexit_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    force_exit_req == cpu_rdata[2]);

  assert_fexit_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr_en && fexit_hw_clr) |=> !force_exit_req);

  assert_static_sdr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    static_sdr_active == (cpu_rdata[1] && !dyn_addr_valid));

  assert_ack_policy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ackp_en && addr_match) |-> (ack_decision == cpu_rdata[0]) && ack_decision_valid);

  assert_ack_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ackp_en && addr_match) |-> ack_decision);

  assert_oneshot_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr_en && ackone_hw_clr) |=> !cpu_rdata[0]);

  assert_sw_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && (fexit_hw_clr || ackone_hw_clr)) |=>
      (cpu_rdata[0] == $past(cpu_wdata[0])));

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_en |=> (cpu_rdata[3] == $past(cpu_wdata[3])) &&
                  (cpu_rdata[1] == $past(cpu_wdata[1])));
endmodule

bind tgt_ctl_reg tgt_ctl_reg_chk u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .cpu_wr_en          (cpu_wr_en),
  .cpu_wdata          (cpu_wdata),
  .cpu_rdata          (cpu_rdata),
  .op_mode            (op_mode),
  .fexit_hw_clr       (fexit_hw_clr),
  .ackone_hw_clr      (ackone_hw_clr),
  .addr_match         (addr_match),
  .dyn_addr_valid     (dyn_addr_valid),
  .ackp_en            (ackp_en),
  .force_exit_req     (force_exit_req),
  .static_sdr_active  (static_sdr_active),
  .ack_decision       (ack_decision),
  .ack_decision_valid (ack_decision_valid)
);

// File: tb/tgt_ctl_reg_test.sv
module tgt_ctl_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr_en = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic [1:0] op_mode = 2'b00;
  logic       hdr_exit_done = 1'b0;
  logic       addr_match = 1'b0;
  logic       ack_sent = 1'b0;
  logic       dyn_addr_valid = 1'b0;
  logic       ackp_en = 1'b0;
  logic       force_exit_req, static_sdr_active, ack_decision, ack_decision_valid;

  always #2.5 clk = ~clk;

  tgt_ctl_reg uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .op_mode(op_mode), .hdr_exit_done(hdr_exit_done),
    .addr_match(addr_match), .ack_sent(ack_sent), .dyn_addr_valid(dyn_addr_valid),
    .ackp_en(ackp_en), .force_exit_req(force_exit_req),
    .static_sdr_active(static_sdr_active), .ack_decision(ack_decision),
    .ack_decision_valid(ack_decision_valid)
  );

  typedef struct {
    string      req;
    logic [7:0] rd;
    logic       fe;
    logic       ss;
    logic       ad;
    logic       av;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  // Reference state, kept from the requirement text: {errdet, fexit, statsdr, one-shot}
  logic [3:0] m = 4'h0;

  task automatic drive(input string req, input logic wr, input logic [7:0] wd,
                       input logic [1:0] mode, input logic xdone, input logic am,
                       input logic as, input logic dav, input logic ackp);
    exp_t e;
    @(negedge clk);
    cpu_wr_en = wr; cpu_wdata = wd; op_mode = mode; hdr_exit_done = xdone;
    addr_match = am; ack_sent = as; dyn_addr_valid = dav; ackp_en = ackp;
    if (wr) begin
      m[3] = wd[3];
      m[1] = wd[1];
      m[0] = wd[0];
      m[2] = (mode == 2'b10 || mode == 2'b11) ? wd[2] : 1'b0;
    end else begin
      if (xdone) m[2] = 1'b0;
      if (as)    m[0] = 1'b0;
    end
    @(posedge clk);
    #1;
    e.req = req;
    e.rd  = {4'b0000, m};
    e.fe  = m[2];
    e.ss  = m[1] && !dav;
    e.ad  = ackp ? m[0] : 1'b1;
    e.av  = am;
    exp_q.push_back(e);
  endtask

  // Monitor: compare every queued expectation against the outputs.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (cpu_rdata !== e.rd || force_exit_req !== e.fe || static_sdr_active !== e.ss ||
            ack_decision !== e.ad || ack_decision_valid !== e.av) begin
          n_fail++;
          $display("FAIL %s: rdata=%h fe=%b ss=%b ad=%b av=%b expected rdata=%h fe=%b ss=%b ad=%b av=%b",
                   e.req, cpu_rdata, force_exit_req, static_sdr_active, ack_decision,
                   ack_decision_valid, e.rd, e.fe, e.ss, e.ad, e.av);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    //                 wr  wdata  mode   done am as dav ackp
    drive("R1 reset",  0, 8'h00, 2'b00, 0, 0, 0, 0, 0);
    drive("R2 upper",  1, 8'hFA, 2'b00, 0, 0, 0, 0, 0);  // R5 static SDR on
    drive("R5 dynaddr",0, 8'h00, 2'b00, 0, 0, 0, 1, 0);
    drive("R3 sdr01",  1, 8'h0E, 2'b01, 0, 0, 0, 1, 0);
    drive("R3 sdr00",  1, 8'h0E, 2'b00, 0, 0, 0, 0, 0);
    drive("R3 hdr",    1, 8'h0E, 2'b10, 0, 0, 0, 0, 0);
    drive("R3 level",  0, 8'h00, 2'b11, 0, 0, 0, 0, 0);
    drive("R4 hwclr",  0, 8'h00, 2'b11, 1, 0, 0, 0, 0);
    drive("R10 write", 1, 8'h04, 2'b10, 0, 0, 0, 0, 0);
    drive("R4 swclr",  1, 8'h00, 2'b10, 0, 0, 0, 0, 0);
    drive("R10 arm",   1, 8'h05, 2'b10, 0, 0, 0, 0, 0);
    drive("R9 race",   1, 8'h05, 2'b10, 1, 0, 1, 0, 0);
    drive("R6 ack",    0, 8'h00, 2'b10, 0, 1, 0, 0, 1);
    drive("R8 clear",  0, 8'h00, 2'b10, 0, 0, 1, 0, 1);
    drive("R6 nack",   0, 8'h00, 2'b10, 0, 1, 0, 0, 1);
    drive("R7 default",0, 8'h00, 2'b10, 0, 1, 0, 0, 0);
    drive("R7 idle",   0, 8'h00, 2'b10, 0, 0, 0, 0, 0);
    drive("R9 rearm",  1, 8'h01, 2'b00, 0, 0, 1, 0, 1);
    drive("R8 clear2", 0, 8'h00, 2'b00, 0, 1, 1, 0, 1);
    drive("R2 hiwrite",1, 8'hF0, 2'b10, 0, 0, 0, 0, 0);
    drive("R1 settle", 0, 8'h00, 2'b00, 0, 0, 0, 0, 0);
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule